// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo stream of two's-complement audio samples from a three-wire serial link: a bit clock, a word clock that tells which channel is on the wire, and a data line. All of its logic runs on the bit clock, and data is sampled on that clock's rising edge. A 2-bit select input chooses one of four framings. The framings differ in where a word starts or ends relative to a word-clock change, and in which word-clock level marks the left channel.

Every word is sent most significant bit first. The block returns each word left-aligned in a 24-bit field. When a word is shorter than the field, the low bits are filled with zeros, so the sign bit stays in the top position. After the right word of a frame completes, the block presents the left and right samples together with a one-cycle strobe. The outputs then hold until the next pair arrives.

Top module: `serial_audio_rx`

## Requirements
- R1: With select 00 (I2S framing), the first bit of a word is sampled one bit clock after the word clock changes, and a word received while the word clock is low is the left sample.
- R2: With select 01 (left-justified framing), the first bit of a word is sampled in the first bit clock after the word clock changes, and a word received while the word clock is high is the left sample.
- R3: With select 10 (right-justified, 24-bit), the 24 bits sampled last before a word-clock change form the word, and high marks the left channel.
- R4: With select 11 (right-justified, 16-bit), the 16 bits sampled last before a word-clock change are placed in output bits 23:8 and bits 7:0 are zero; high marks the left channel.
- R5: In select 00 and 01, bits after the 24th in a half-frame are ignored, and a half-frame shorter than 24 bits leaves the output bits below the received ones at zero.
- R6: In select 10 and 11, bits sent in a half-frame before the word's own bits are ignored.
- R7: `pair_valid` is high for exactly one cycle per frame. It rises in the cycle after the rising edge that samples the first bit slot of the next half-frame (select 01, 10, 11), or the second slot (select 00).
- R8: `left_sample` and `right_sample` change only together with `pair_valid`, and finishing a left word alone never raises `pair_valid`.
- R9: During and after reset the outputs are zero and `pair_valid` is low. No pair is issued until a left word and then a right word have each been received in full after the first word-clock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; data sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified 24-bit, 11 right-justified 16-bit |
| word_clk | input | 1 | Left/right word clock |
| sdata | input | 1 | Serial data, MSB first |
| left_sample | output | 24 | Left sample, left-aligned two's complement |
| right_sample | output | 24 | Right sample, left-aligned two's complement |
| pair_valid | output | 1 | One-cycle strobe when a new sample pair is presented |

## Verification
The bench builds the receiver with its default 24-bit sample field and a 16-bit short word. It sweeps every framing select against half-frame lengths of 16, 20, 24, 25 and 32 bit clocks, as far as each framing allows. Half-frames shorter than 24 slots reach the zero-fill case. Longer ones pad the spare slots with ones, which shows that those bits are ignored. The first frame carries the most negative and most positive values, so the sign position is checked. The bench also checks the exact cycle of every strobe, the hold of the outputs between strobes, and the absence of a pair from the partial half-frame seen just after reset.

// File: rtl/sar_pkg.sv
// Shared definitions for the serial audio receiver.
package sar_pkg;
    // Framing select codes; the code values are fixed by the select input.
    typedef enum logic [1:0] {
        FMT_I2S         = 2'b00,
        FMT_LEFT_JUST   = 2'b01,
        FMT_RIGHT_LONG  = 2'b10,
        FMT_RIGHT_SHORT = 2'b11
    } sar_fmt_e;
endpackage

// File: rtl/sar_frame_ref.sv
// Word-clock tracker: marks the cycle where a new word starts under the
// selected framing, and says whether the word that just ended was left.
// Assumes word_clk is already synchronous to clk (the bit clock).
// I2S is handled as left-justified framing on a one-cycle delayed word clock.
module sar_frame_ref
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     word_clk,
    input  sar_fmt_e fmt,
    output logic     word_edge,
    output logic     done_left
);
    logic wc_d;
    logic wc_dd;
    logic ref_now;
    logic ref_prev;

    // Delay line for the word clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc_d  <= 1'b0;
            wc_dd <= 1'b0;
        end else begin
            wc_d  <= word_clk;
            wc_dd <= wc_d;
        end
    end

    // Pick the reference word clock and polarity for the framing in use.
    always_comb begin
        if (fmt == FMT_I2S) begin
            ref_now   = wc_d;
            ref_prev  = wc_dd;
            done_left = ~wc_dd;
        end else begin
            ref_now   = word_clk;
            ref_prev  = wc_d;
            done_left = wc_d;
        end
        word_edge = ref_now ^ ref_prev;
    end
endmodule

// File: rtl/sar_lj_collect.sv
// Front-aligned word collector: starts a word at word_edge with the bit
// present in that cycle and fills up to W bits MSB first. Bits beyond W are
// dropped; bits never received stay zero. word_done holds the word built so
// far and is read by the parent on the next word_edge.
module sar_lj_collect #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdata,
    input  logic         word_edge,
    output logic [W-1:0] word_done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [W-1:0] TOP_BIT = W'(1) << (W - 1);

    logic [W-1:0]  acc;
    logic [CW-1:0] cnt;

    // Restart on a word boundary, otherwise place the next bit below the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
        end else if (word_edge) begin
            acc <= sdata ? TOP_BIT : '0;
            cnt <= CW'(1);
        end else if (cnt < CW'(W)) begin
            if (sdata) begin
                acc <= acc | (TOP_BIT >> cnt);
            end
            cnt <= cnt + CW'(1);
        end
    end

    assign word_done = acc;
endmodule

// File: rtl/sar_rj_window.sv
// Back-aligned word window: keeps the last W bits seen on the data line, so
// at a word boundary it holds the word that ended in the previous cycle.
// In short mode only the last SHORT_W bits are kept, moved to the top.
module sar_rj_window #(
    parameter int W       = 24,
    parameter int SHORT_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdata,
    input  logic         short_mode,
    output logic [W-1:0] word_done
);
    logic [W-1:0] sh;
    logic [W-1:0] short_word;

    // Continuous MSB-first shift of the data line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[W-2:0], sdata};
        end
    end

    // Left-align the short word, zero-filling the low bits.
    if (SHORT_W < W) begin : g_pad
        assign short_word = {sh[SHORT_W-1:0], {(W - SHORT_W){1'b0}}};
    end else begin : g_full
        assign short_word = sh;
    end

    assign word_done = short_mode ? short_word : sh;
endmodule

// File: rtl/serial_audio_rx.sv
// Multi-format serial audio receiver top. Runs entirely on the bit clock.
// Words end at word-clock boundaries picked by sar_frame_ref. A left word is
// parked until the following right word ends; then both are presented with
// a single-cycle pair_valid. Assumes fmt is changed only while in reset.
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt,
    input  logic                word_clk,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                pair_valid
);
    sar_fmt_e            fmt_e;
    logic                word_edge;
    logic                done_left;
    logic                right_mode;
    logic [SAMPLE_W-1:0] lj_word;
    logic [SAMPLE_W-1:0] rj_word;
    logic [SAMPLE_W-1:0] finished;
    logic [SAMPLE_W-1:0] left_hold;
    logic                left_fresh;
    logic                have_word;

    assign fmt_e      = sar_fmt_e'(fmt);
    assign right_mode = (fmt_e == FMT_RIGHT_LONG) || (fmt_e == FMT_RIGHT_SHORT);

    sar_frame_ref u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_clk (word_clk),
        .fmt      (fmt_e),
        .word_edge(word_edge),
        .done_left(done_left)
    );

    sar_lj_collect #(.W(SAMPLE_W)) u_lj (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdata    (sdata),
        .word_edge(word_edge),
        .word_done(lj_word)
    );

    sar_rj_window #(.W(SAMPLE_W), .SHORT_W(SHORT_W)) u_rj (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdata     (sdata),
        .short_mode(fmt_e == FMT_RIGHT_SHORT),
        .word_done (rj_word)
    );

    // Select the word that ends at this boundary.
    always_comb begin
        finished = right_mode ? rj_word : lj_word;
    end

    // Park left words and present complete pairs with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold    <= '0;
            left_fresh   <= 1'b0;
            have_word    <= 1'b0;
            left_sample  <= '0;
            right_sample <= '0;
            pair_valid   <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (word_edge) begin
                have_word <= 1'b1;
                if (have_word) begin
                    if (done_left) begin
                        left_hold  <= finished;
                        left_fresh <= 1'b1;
                    end else if (left_fresh) begin
                        left_sample  <= left_hold;
                        right_sample <= finished;
                        pair_valid   <= 1'b1;
                        left_fresh   <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/serial_audio_rx_checker.sv
// Property checker for serial_audio_rx, attached by the bind below.
module serial_audio_rx_checker #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   fmt,
    input logic         pair_valid,
    input logic [W-1:0] left_sample,
    input logic [W-1:0] right_sample,
    input logic         word_edge,
    input logic         done_left
);
    AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && fmt == 2'b11) |-> (left_sample[7:0] == 8'h00 && right_sample[7:0] == 8'h00)); // R4

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid); // R7

    AST_VALID_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ($past(word_edge) && !$past(done_left))); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_sample) && $stable(right_sample))); // R8

    AST_LEFT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_edge && done_left) |=> !pair_valid); // R8
endmodule

bind serial_audio_rx serial_audio_rx_checker #(.W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt         (fmt),
    .pair_valid  (pair_valid),
    .left_sample (left_sample),
    .right_sample(right_sample),
    .word_edge   (word_edge),
    .done_left   (done_left)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
    localparam int FRAMES = 4;
    localparam int IDLE   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        word_clk = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_sample;
    logic [23:0] right_sample;
    logic        pair_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    serial_audio_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt         (fmt),
        .word_clk    (word_clk),
        .sdata       (sdata),
        .left_sample (left_sample),
        .right_sample(right_sample),
        .pair_valid  (pair_valid)
    );

    // Test words: frame 0 carries the extremes of the two's-complement range.
    function automatic logic [23:0] word_of(int p, int ch);
        logic [23:0] x;
        if (p == 0) return (ch == 0) ? 24'h800000 : 24'h7FFFFF;
        if (p == 1) return (ch == 0) ? 24'hFFFFFF : 24'h000100;
        x = 24'(p * 32'h3A5C17 + 32'h1234);
        return (ch == 0) ? x : (~x ^ 24'(p << 4));
    endfunction

    function automatic int word_bits(int f, int s);
        if (f == 2) return 24;
        if (f == 3) return 16;
        return (s < 24) ? s : 24;
    endfunction

    function automatic logic [23:0] keep_mask(int n);
        return 24'hFFFFFF << (24 - n);
    endfunction

    // Front-aligned stream bit at stream slot u; spare slots carry ones.
    function automatic logic front_bit(int u, int s);
        int h, k;
        logic [23:0] w;
        if (u < 0) return 1'b0;
        h = u / s;
        k = u % s;
        if (h >= 2 * FRAMES) return 1'b0;
        w = word_of(h / 2, h % 2);
        return (k < 24) ? w[23 - k] : 1'b1;
    endfunction

    // Back-aligned stream bit at stream slot u; leading spare slots carry ones.
    function automatic logic back_bit(int u, int s, int n);
        int h, idx;
        logic [23:0] w;
        if (u < 0) return 1'b0;
        h = u / s;
        if (h >= 2 * FRAMES) return 1'b0;
        idx = s - 1 - (u % s);
        w = word_of(h / 2, h % 2);
        return (idx < n) ? w[24 - n + idx] : 1'b1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_cfg(int f, int s);
        int n, total, pairs, u, h, exp_slot;
        logic left_lvl;
        logic [23:0] last_l, last_r;
        string tag;
        n = word_bits(f, s);
        left_lvl = (f == 0) ? 1'b0 : 1'b1;
        tag = (f == 0) ? "R1" : (f == 1) ? "R2" : (f == 2) ? "R3" : "R4";
        if (f < 2 && s != 24) tag = {tag, "/R5"};
        if (f >= 2 && s > n) tag = {tag, "/R6"};

        // R9: reset state
        @(negedge clk);
        rst_n = 1'b0;
        fmt = 2'(f);
        word_clk = ~left_lvl;
        sdata = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset left", 32'(left_sample), 32'h0);
        check("R9 reset right", 32'(right_sample), 32'h0);
        check("R9 reset valid", 32'(pair_valid), 32'h0);
        rst_n = 1'b1;

        total = IDLE + (2 * FRAMES + 1) * s + 4;
        pairs = 0;
        last_l = '0;
        last_r = '0;
        for (int g = 0; g < total; g++) begin
            u = g - IDLE;
            if (u < 0) begin
                word_clk = ~left_lvl;
                sdata = 1'b0;
            end else begin
                h = u / s;
                if (h > 2 * FRAMES) h = 2 * FRAMES;
                word_clk = (h % 2 == 0) ? left_lvl : ~left_lvl;
                if (f == 0) sdata = front_bit(u - 1, s);
                else if (f == 1) sdata = front_bit(u, s);
                else sdata = back_bit(u, s, n);
            end
            @(negedge clk);
            if (pair_valid) begin
                exp_slot = (2 * pairs + 2) * s + ((f == 0) ? 1 : 0);
                check($sformatf("R7 strobe slot fmt%0d s%0d", f, s), 32'(u), 32'(exp_slot));
                check($sformatf("%s left fmt%0d s%0d pair%0d", tag, f, s, pairs),
                      32'(left_sample), 32'(word_of(pairs, 0) & keep_mask(n)));
                check($sformatf("%s right fmt%0d s%0d pair%0d", tag, f, s, pairs),
                      32'(right_sample), 32'(word_of(pairs, 1) & keep_mask(n)));
                last_l = left_sample;
                last_r = right_sample;
                pairs++;
            end else begin
                // R8: outputs hold between strobes
                check("R8 hold left", 32'(left_sample), 32'(last_l));
                check("R8 hold right", 32'(right_sample), 32'(last_r));
            end
        end
        // R9: no extra pair from the partial word seen after reset
        check($sformatf("R9 pair count fmt%0d s%0d", f, s), 32'(pairs), 32'(FRAMES));
    endtask

    initial begin
        run_cfg(0, 16); run_cfg(0, 20); run_cfg(0, 24); run_cfg(0, 32);
        run_cfg(1, 16); run_cfg(1, 20); run_cfg(1, 24); run_cfg(1, 32);
        run_cfg(2, 24); run_cfg(2, 25); run_cfg(2, 32);
        run_cfg(3, 16); run_cfg(3, 24); run_cfg(3, 32);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule